// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the configuration front end of an eight-line interrupt controller. A processor reaches it through a small bus made of one address bit, a write strobe, a read strobe and an 8-bit data path. Software programs the controller by writing a short series of setup words. The first word goes to the even address, and every later word goes to the odd address. The block tracks which setup word the next odd-address write represents. Flags in the first word decide whether the cascade word and the mode word are part of the series or are skipped.

When the last expected word has been accepted, the block enters its operating state and raises `init_done`. From then on, writes to the odd address load the per-line mask and reads from the odd address return it. The block also exports the stored configuration, so that the priority, in-service and cascade logic elsewhere can use it. It computes a vector number for each request line and marks whether that line is currently enabled.

Top module: `irqi_top`

## Requirements
- R1: An even-address write whose bits 7..4 are 0001 is the first setup word, whatever the current state. After it, `init_done` is low, the next odd write is taken as the second word, `line_mask` reads zero, and the mode-word outputs (`vec8_mode`, `auto_eoi`, `buffered`, `buf_master`) are cleared.
- R2: Bit 0 of the first word set means a mode word follows the last of the other words. Clear means the series ends without it.
- R3: Bit 1 of the first word set means single-controller operation. The cascade word is skipped and `single_mode` is 1. Clear means the cascade word follows the second word.
- R4: Bit 3 of the first word is stored and driven on `trig_level`.
- R5: The second word sets `vec_base` to its bits 7..3. Its bits 2..0 are discarded.
- R6: The cascade word is stored whole on `cascade_mask`, and its bits 2..0 are driven on `slave_id`.
- R7: In the mode word, bit 0 drives `vec8_mode`, bit 1 drives `auto_eoi` and bit 3 drives `buffered`. `buf_master` takes bit 2 only when bit 3 is also set, and is 0 otherwise.
- R8: While `init_done` is high, an odd write loads `line_mask`. A read with `bus_addr`=1 and `init_done` high returns `line_mask` on `bus_rdata`. Every other read returns zero.
- R9: An even-address write whose bits 7..4 are not 0001 changes nothing. An odd-address write before any first word has been received changes nothing.
- R10: `line_vec` slice n (bits 8n+7..8n) equals {`vec_base`, n[2:0]}. `line_vec_valid[n]` is 1 exactly when `init_done` is high and `line_mask[n]` is 0.
- R11: `init_done` is high exactly when the final expected word has been accepted. After a synchronous active-low reset, all outputs are zero and the block waits for a first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select, even (0) or odd (1) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (mask or zero) |
| init_done | output | 1 | Setup series complete |
| vec_base | output | 5 | Vector base from the second word |
| trig_level | output | 1 | Request reporting mode flag |
| single_mode | output | 1 | Single controller, no cascade word |
| cascade_mask | output | 8 | Stored cascade word |
| slave_id | output | 3 | Low three bits of the cascade word |
| vec8_mode | output | 1 | 8-bit vector mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| buffered | output | 1 | Buffered mode enabled |
| buf_master | output | 1 | Master select, qualified by buffered |
| line_mask | output | 8 | Per-line disable mask |
| line_vec | output | 64 | Vector number per line, 8 bits each |
| line_vec_valid | output | 8 | Line enabled and block ready |

## Verification
The bench goes after the step skipping. If the single flag or the mode-word flag were decoded wrongly, `init_done` would rise one write too early or too late, or a cascade value would land in the mode fields. It restarts the series partway through and checks that a sequencer which ignored the restart would finish early with the stale base. It also writes bit 2 of the mode word without bit 3 to catch an unqualified master flag. Finally, it makes ignored writes (a wrong tag at the even address, an odd write before any first word, an even write while ready) and confirms that none of them moves the state, the base or the mask.

// File: rtl/irqi_pkg.sv
// Package irqi_pkg
// Shared types and constants for the interrupt setup sequencer.
// Assumes an 8-bit data bus and a single address bit.
package irqi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT2 = 3'd1,
        ST_WAIT3 = 3'd2,
        ST_WAIT4 = 3'd3,
        ST_READY = 3'd4
    } seq_state_t;

    // Upper-nibble tag that marks the first setup word at the even address.
    localparam logic [3:0] WORD1_TAG = 4'b0001;
endpackage

// File: rtl/irqi_seq.sv
// Module irqi_seq
// Tracks which setup word the next odd-address write represents and
// produces one load strobe per accepted word.
// Assumes the skip flags come from the stored first word (stable once
// that word has been taken), and that word1_i and odd_wr_i never
// occur in the same cycle.
module irqi_seq
    import irqi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word1_i,
    input  logic       odd_wr_i,
    input  logic       single_i,
    input  logic       want4_i,
    output seq_state_t state_o,
    output logic       ld2_o,
    output logic       ld3_o,
    output logic       ld4_o,
    output logic       ldmask_o
);
    seq_state_t state_q, state_d;

    // Next-state selection and load strobes for the current write.
    always_comb begin
        state_d  = state_q;
        ld2_o    = 1'b0;
        ld3_o    = 1'b0;
        ld4_o    = 1'b0;
        ldmask_o = 1'b0;
        if (word1_i) begin
            state_d = ST_WAIT2;
        end else if (odd_wr_i) begin
            unique case (state_q)
                ST_WAIT2: begin
                    ld2_o = 1'b1;
                    if (!single_i)    state_d = ST_WAIT3;
                    else if (want4_i) state_d = ST_WAIT4;
                    else              state_d = ST_READY;
                end
                ST_WAIT3: begin
                    ld3_o   = 1'b1;
                    state_d = want4_i ? ST_WAIT4 : ST_READY;
                end
                ST_WAIT4: begin
                    ld4_o   = 1'b1;
                    state_d = ST_READY;
                end
                ST_READY: ldmask_o = 1'b1;
                default:  state_d  = state_q;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    AST_RESTART_TO_WORD2: assert property (@(posedge clk) disable iff (!rst_n)
        word1_i |=> state_q == ST_WAIT2); // R1
    AST_IDLE_ODD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && odd_wr_i && !word1_i) |=> state_q == ST_IDLE); // R9
    AST_SINGLE_SKIPS_W3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT2 && odd_wr_i && !word1_i && single_i) |=> state_q != ST_WAIT3); // R3
    AST_W4_ENDS_SERIES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT4 && odd_wr_i && !word1_i) |=> state_q == ST_READY); // R2
endmodule

// File: rtl/irqi_cfg.sv
// Module irqi_cfg
// Holds the configuration captured from the setup words.
// Assumes at most one load strobe per cycle. The first word clears the
// mode-word fields, so a series without a mode word leaves them zero.
module irqi_cfg #(
    parameter int DW = 8,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld1_i,
    input  logic          ld2_i,
    input  logic          ld3_i,
    input  logic          ld4_i,
    input  logic [DW-1:0] wdata_i,
    output logic          want4_o,
    output logic          single_o,
    output logic          level_o,
    output logic [DW-LW-1:0] base_o,
    output logic [DW-1:0] casc_o,
    output logic          vec8_o,
    output logic          aeoi_o,
    output logic          buf_o,
    output logic          bufm_o
);
    // First-word flags: mode-word present, single controller, level mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want4_o  <= 1'b0;
            single_o <= 1'b0;
            level_o  <= 1'b0;
        end else if (ld1_i) begin
            want4_o  <= wdata_i[0];
            single_o <= wdata_i[1];
            level_o  <= wdata_i[3];
        end
    end

    // Vector base: upper bits of the second word; the low bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)     base_o <= '0;
        else if (ld2_i) base_o <= wdata_i[DW-1:LW];
    end

    // Cascade word, stored whole.
    always_ff @(posedge clk) begin
        if (!rst_n)     casc_o <= '0;
        else if (ld3_i) casc_o <= wdata_i;
    end

    // Mode-word fields, cleared by a new first word.
    always_ff @(posedge clk) begin
        if (!rst_n || ld1_i) begin
            vec8_o <= 1'b0;
            aeoi_o <= 1'b0;
            buf_o  <= 1'b0;
            bufm_o <= 1'b0;
        end else if (ld4_i) begin
            vec8_o <= wdata_i[0];
            aeoi_o <= wdata_i[1];
            buf_o  <= wdata_i[3];
            bufm_o <= wdata_i[3] & wdata_i[2];
        end
    end

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld2_i |=> $stable(base_o)); // R5
    AST_BUFM_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        bufm_o |-> buf_o); // R7
endmodule

// File: rtl/irqi_mask.sv
// Module irqi_mask
// Per-line disable mask and its read path.
// Assumes the clear and load strobes are never active in the same cycle.
module irqi_mask #(
    parameter int NL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          ld_i,
    input  logic [NL-1:0] wdata_i,
    input  logic          rd_en_i,
    output logic [NL-1:0] mask_o,
    output logic [NL-1:0] rdata_o
);
    // Mask register: cleared by reset or by a new first word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) mask_o <= '0;
        else if (ld_i)       mask_o <= wdata_i;
    end

    // Read mux: returns the mask only when the read is enabled.
    always_comb rdata_o = rd_en_i ? mask_o : '0;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !clr_i) |=> $stable(mask_o)); // R8
endmodule

// File: rtl/irqi_top.sv
// Module irqi_top
// Setup-word sequencer for an eight-line interrupt controller. It
// decodes the bus, steps through the setup words, stores the
// configuration, owns the line mask and derives per-line vectors.
// Assumes one-cycle write strobes and a synchronous active-low reset.
module irqi_top
    import irqi_pkg::*;
#(
    parameter int NL = 8,
    parameter int DW = 8,
    localparam int LW = $clog2(NL),
    localparam int BW = DW - LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             init_done,
    output logic [BW-1:0]    vec_base,
    output logic             trig_level,
    output logic             single_mode,
    output logic [DW-1:0]    cascade_mask,
    output logic [LW-1:0]    slave_id,
    output logic             vec8_mode,
    output logic             auto_eoi,
    output logic             buffered,
    output logic             buf_master,
    output logic [NL-1:0]    line_mask,
    output logic [NL*DW-1:0] line_vec,
    output logic [NL-1:0]    line_vec_valid
);
    logic       word1, odd_wr, want4, ld2, ld3, ld4, ldmask;
    seq_state_t state;
    logic [NL-1:0] rdata_m;

    // Bus decode: the tagged even write is the first word; odd writes step.
    always_comb begin
        word1  = bus_wr && !bus_addr && (bus_wdata[DW-1:DW-4] == WORD1_TAG);
        odd_wr = bus_wr &&  bus_addr;
    end

    irqi_seq u_seq (
        .clk(clk), .rst_n(rst_n), .word1_i(word1), .odd_wr_i(odd_wr),
        .single_i(single_mode), .want4_i(want4), .state_o(state),
        .ld2_o(ld2), .ld3_o(ld3), .ld4_o(ld4), .ldmask_o(ldmask)
    );

    irqi_cfg #(.DW(DW), .LW(LW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ld1_i(word1), .ld2_i(ld2), .ld3_i(ld3),
        .ld4_i(ld4), .wdata_i(bus_wdata), .want4_o(want4),
        .single_o(single_mode), .level_o(trig_level), .base_o(vec_base),
        .casc_o(cascade_mask), .vec8_o(vec8_mode), .aeoi_o(auto_eoi),
        .buf_o(buffered), .bufm_o(buf_master)
    );

    irqi_mask #(.NL(NL)) u_mask (
        .clk(clk), .rst_n(rst_n), .clr_i(word1), .ld_i(ldmask),
        .wdata_i(bus_wdata[NL-1:0]), .rd_en_i(bus_rd && bus_addr && init_done),
        .mask_o(line_mask), .rdata_o(rdata_m)
    );

    // Ready flag and read data widening.
    always_comb begin
        init_done = (state == ST_READY);
        bus_rdata = DW'(rdata_m);
        slave_id  = cascade_mask[LW-1:0];
    end

    // Per-line vector and enable, one slice per request line.
    for (genvar n = 0; n < NL; n++) begin : g_line
        always_comb begin
            line_vec[n*DW +: DW] = {vec_base, LW'(n)};
            line_vec_valid[n]    = init_done && !line_mask[n];
        end
    end

    AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vec_valid != '0) |-> init_done); // R10
    AST_DONE_LOW_AFTER_W1: assert property (@(posedge clk) disable iff (!rst_n)
        word1 |=> !init_done && line_mask == '0); // R1
    AST_IGNORED_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && !word1) |=> $stable(init_done) && $stable(vec_base)); // R9
endmodule

// File: tb/irqi_top_tb_top.sv
module irqi_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        init_done, trig_level, single_mode, vec8_mode, auto_eoi, buffered, buf_master;
    logic [4:0]  vec_base;
    logic [7:0]  cascade_mask, line_mask, line_vec_valid;
    logic [2:0]  slave_id;
    logic [63:0] line_vec;
    int checks = 0, fails = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    irqi_top dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // {addr, data, expected init_done after the write}
    localparam logic [9:0] VEC [11] = '{
        {1'b0, 8'h11, 1'b0},  // R1 first word: cascade, mode word follows
        {1'b1, 8'h21, 1'b0},  // R5 second word
        {1'b1, 8'h04, 1'b0},  // R6 cascade word
        {1'b1, 8'h03, 1'b1},  // R2 mode word ends the series
        {1'b1, 8'hF0, 1'b1},  // R8 mask write
        {1'b0, 8'h55, 1'b1},  // R9 untagged even write ignored
        {1'b0, 8'h13, 1'b0},  // R3 single, mode word follows
        {1'b1, 8'h48, 1'b0},  // R3 second word, cascade skipped
        {1'b1, 8'h01, 1'b1},  // R2 mode word
        {1'b0, 8'h1A, 1'b0},  // R4 single, level, no mode word
        {1'b1, 8'h80, 1'b1}   // R2 series ends at second word
    };

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 done", init_done, 0);
        chk("R11 base", vec_base, 0);
        chk("R11 mask", line_mask, 0);
        chk("R11 valid", line_vec_valid, 0);
        rst_n = 1'b1;
        // R9 odd write before any first word
        wr(1'b1, 8'hF8);
        chk("R9 idle odd base", vec_base, 0);
        chk("R9 idle odd done", init_done, 0);
        wr(1'b1, 8'h08);
        chk("R9 idle odd done 2", init_done, 0);

        foreach (VEC[i]) begin
            wr(VEC[i][9], VEC[i][8:1]);
            chk($sformatf("R2 R3 table step %0d done", i), init_done, VEC[i][0]);
        end
        chk("R4 level", trig_level, 1);
        chk("R3 single", single_mode, 1);
        chk("R5 base", vec_base, 5'h10);
        chk("R1 mode fields cleared", {vec8_mode, auto_eoi, buffered, buf_master}, 0);
        chk("R1 mask cleared", line_mask, 0);

        // R8 mask write and reads
        wr(1'b1, 8'h05);
        chk("R8 mask", line_mask, 8'h05);
        rd(1'b1, r); chk("R8 read odd", r, 8'h05);
        rd(1'b0, r); chk("R8 read even", r, 8'h00);
        // R10 vectors
        chk("R10 valid", line_vec_valid, 8'hFA);
        chk("R10 vec1", line_vec[15:8], 8'h81);
        chk("R10 vec7", line_vec[63:56], 8'h87);
        // R9 untagged even write in ready
        wr(1'b0, 8'h20);
        chk("R9 even ignored done", init_done, 1);
        chk("R9 even ignored mask", line_mask, 8'h05);

        // R1 restart in the middle of a series
        wr(1'b0, 8'h11);
        rd(1'b1, r); chk("R8 read not ready", r, 8'h00);
        wr(1'b1, 8'h20);
        wr(1'b0, 8'h19);
        chk("R1 restart done", init_done, 0);
        wr(1'b1, 8'h37);
        chk("R5 base low bits dropped", vec_base, 5'h06);
        chk("R1 still waiting", init_done, 0);
        wr(1'b1, 8'hA5);
        chk("R6 cascade", cascade_mask, 8'hA5);
        chk("R6 slave id", slave_id, 3'd5);
        chk("R6 not done", init_done, 0);
        wr(1'b1, 8'h0A);
        chk("R7 fields 0A", {vec8_mode, auto_eoi, buffered, buf_master}, 4'b0110);
        chk("R11 done", init_done, 1);
        chk("R4 level 19", trig_level, 1);

        // R7 master bit without buffered
        wr(1'b0, 8'h13); wr(1'b1, 8'h08); wr(1'b1, 8'h04);
        chk("R7 bufm unqualified", {buffered, buf_master}, 2'b00);
        chk("R7 done", init_done, 1);
        wr(1'b0, 8'h13); wr(1'b1, 8'h08); wr(1'b1, 8'h0D);
        chk("R7 fields 0D", {vec8_mode, auto_eoi, buffered, buf_master}, 4'b1011);

        // R11 reset from ready
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11 reset done", init_done, 0);
        chk("R11 reset fields", {vec_base, cascade_mask, vec8_mode, buffered}, 0);
        done_flag = 1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog act=timeout exp=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule